// File: doc/BRIEF.md
# Cache-as-RAM Window Decoder

This block serves the 64 MB address window from 0x7C000000 to 0x7FFFFFFF when half of the operand cache is set aside as directly addressed scratch RAM. A small control register holds three bits: cache enable, RAM enable and an index-mode select. For each access the block decides whether the window claims it. It then picks one of two 4 KB RAM pages and forms the byte offset into the 16 KB cache data array. The two pages are the upper halves of the two cache ways.

The block also holds the RAM bytes of both pages. It carries out byte, word and long reads and writes. Read data comes back one cycle after the request, sign-extended to 32 bits for byte and word sizes. A write changes only the bytes that its size covers. A request that falls in the window while the control bits do not enable RAM reports a decode error. A misaligned request reports an address error and has no effect.

Top module: `car_ram_window`

## Requirements
- R1: A request whose address bits 31:26 are not 6'b011111 is not claimed: hit_o and decode_err_o stay low.
- R2: A request inside the window hits only when control bits cache_en (bit 0) and ram_en (bit 1) are both 1. Otherwise decode_err_o is raised and hit_o stays low.
- R3: With index_mode (control bit 2) at 0, address bit 13 selects the page (0 gives page 0, 1 gives page 1).
- R4: With index_mode at 1, address bit 25 selects the page, so the lower 32 MB of the window map to page 0 and the upper 32 MB to page 1.
- R5: offset_o is the byte offset into the 16 KB array: page 0 covers 4096..8191 and page 1 covers 12288..16383. Bits 11:0 equal address bits 11:0, bit 12 is 1 and bit 13 equals page_o.
- R6: A byte read (size_i 0) returns the addressed byte sign-extended from bit 7, with rvalid_o high in the cycle after the request.
- R7: A word read (size_i 1) returns the 16-bit little-endian halfword at the address, sign-extended from bit 15.
- R8: A long read (size_i 2) returns the full little-endian 32-bit word.
- R9: A write stores only the low 1, 2 or 4 bytes of wdata_i that its size covers. All other RAM bytes keep their values.
- R10: A hitting request raises addr_err_o if it is a word at an odd address, a long at an address not divisible by 4, or uses reserved size 3. Such a request writes nothing and gives no rvalid_o.
- R11: A control write takes effect for the request in the following cycle. A request in the same cycle as the control write is decoded with the old value.
- R12: After reset the control register is 0, so window requests give decode_err_o, and rvalid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 3 | {index_mode, ram_en, cache_en} |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| addr_i | input | 32 | Access address |
| wdata_i | input | 32 | Write data, low bytes used |
| hit_o | output | 1 | Window claims and serves the request |
| decode_err_o | output | 1 | In window but RAM mode not enabled |
| addr_err_o | output | 1 | Misaligned or reserved-size hit |
| page_o | output | 1 | Selected RAM page |
| offset_o | output | 14 | Byte offset into the 16 KB data array |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Sign-extended read data |

## Verification
The assertions assume that req_i, we_i, size_i and addr_i are held steady through each cycle. They also assume that a read is followed by a one-cycle look at rvalid_o before the format state is needed again. The stimulus changes inputs only on the falling edge, and it checks every read in the cycle after it is issued.

Random addresses fall mostly inside the window, with both index-mode values and all control combinations. Random accesses use all four size codes. A few addresses land outside the window to exercise the unclaimed path.

// File: rtl/car_pkg.sv
package car_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic index_mode;
    logic ram_en;
    logic cache_en;
  } car_ctrl_t;
endpackage

// File: rtl/car_ctrl_reg.sv
module car_ctrl_reg
  import car_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  car_ctrl_t wdata_i,
  output car_ctrl_t ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_o <= '0;
    else if (we_i) ctrl_o <= wdata_i;
  end
endmodule

// File: rtl/car_decode.sv
module car_decode
  import car_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 26,
  parameter int OFF_W    = 12,
  parameter logic [ADDR_W-WIN_BITS-1:0] WIN_TAG = 6'h1F,
  localparam int ARR_W   = OFF_W + 2
) (
  input  car_ctrl_t         ctrl_i,
  input  logic              req_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              derr_o,
  output logic              aerr_o,
  output logic              page_o,
  output logic [ARR_W-1:0]  offset_o
);
  logic in_win, mode_ok, misal;

  assign in_win  = addr_i[ADDR_W-1:WIN_BITS] == WIN_TAG;
  assign mode_ok = ctrl_i.ram_en & ctrl_i.cache_en;

  // index mode 0 interleaves pages on the bit above one page pair; mode 1 splits the window in halves
  assign page_o = ctrl_i.index_mode ? addr_i[WIN_BITS-1] : addr_i[OFF_W+1];

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: misal = 1'b0;
      SZ_WORD: misal = addr_i[0];
      SZ_LONG: misal = |addr_i[1:0];
      default: misal = 1'b1;
    endcase
  end

  assign hit_o    = req_i & in_win & mode_ok;
  assign derr_o   = req_i & in_win & ~mode_ok;
  assign aerr_o   = hit_o & misal;
  // RAM pages occupy the upper half of each way
  assign offset_o = {page_o, 1'b1, addr_i[OFF_W-1:0]};
endmodule

// File: rtl/car_store.sv
module car_store
  import car_pkg::*;
#(
  parameter int IDX_W  = 11,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        lane_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] wlanes, rd_q;
  logic [1:0]        lane_q;
  acc_size_e         size_q;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        be     = LANES'(1) << lane_i;
        wlanes = {LANES{wdata_i[7:0]}};
      end
      SZ_WORD: begin
        be     = lane_i[1] ? 4'b1100 : 4'b0011;
        wlanes = {2{wdata_i[15:0]}};
      end
      default: begin
        be     = '1;
        wlanes = wdata_i;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk_i) begin
      if (wr_i && be[g]) mem[idx_i] <= wlanes[g*8 +: 8];
      if (rd_i)          rd_q[g*8 +: 8] <= mem[idx_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      lane_q   <= '0;
      size_q   <= SZ_LONG;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) begin
        lane_q <= lane_i;
        size_q <= acc_size_e'(size_i);
      end
    end
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  assign sel_b = rd_q[lane_q*8 +: 8];
  assign sel_h = lane_q[1] ? rd_q[31:16] : rd_q[15:0];

  always_comb begin
    unique case (size_q)
      SZ_BYTE: rdata_o = {{(DATA_W-8){sel_b[7]}}, sel_b};
      SZ_WORD: rdata_o = {{(DATA_W-16){sel_h[15]}}, sel_h};
      default: rdata_o = rd_q;
    endcase
  end
endmodule

// File: rtl/car_ram_window.sv
module car_ram_window
  import car_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 26,
  parameter int OFF_W    = 12,
  parameter logic [ADDR_W-WIN_BITS-1:0] WIN_TAG = 6'h1F,
  localparam int ARR_W   = OFF_W + 2,
  localparam int IDX_W   = OFF_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [2:0]        ctrl_wdata_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              decode_err_o,
  output logic              addr_err_o,
  output logic              page_o,
  output logic [ARR_W-1:0]  offset_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  car_ctrl_t ctrl_q;
  logic      go;

  car_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (car_ctrl_t'(ctrl_wdata_i)),
    .ctrl_o  (ctrl_q)
  );

  car_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .OFF_W(OFF_W), .WIN_TAG(WIN_TAG)
  ) u_dec (
    .ctrl_i   (ctrl_q),
    .req_i    (req_i),
    .size_i   (size_i),
    .addr_i   (addr_i),
    .hit_o    (hit_o),
    .derr_o   (decode_err_o),
    .aerr_o   (addr_err_o),
    .page_o   (page_o),
    .offset_o (offset_o)
  );

  assign go = hit_o & ~addr_err_o;

  car_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (go & we_i),
    .rd_i     (go & ~we_i),
    .idx_i    ({page_o, addr_i[OFF_W-1:2]}),
    .lane_i   (addr_i[1:0]),
    .size_i   (size_i),
    .wdata_i  (wdata_i),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/car_ram_window_chk.sv
module car_ram_window_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [2:0]  ctrl_wdata_i,
  input logic        req_i,
  input logic        we_i,
  input logic [31:0] addr_i,
  input logic        hit_o,
  input logic        decode_err_o,
  input logic        addr_err_o,
  input logic        page_o,
  input logic [13:0] offset_o,
  input logic        rvalid_o
);
  logic win;
  assign win = addr_i[31:26] == 6'h1F;

  AST_OUTSIDE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !win) |-> (!hit_o && !decode_err_o)); // R1

  AST_HIT_DERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && decode_err_o)); // R2

  AST_OFFSET_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (offset_o[12] && offset_o[11:0] == addr_i[11:0] && offset_o[13] == page_o)); // R5

  AST_READ_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !addr_err_o && !we_i) |=> rvalid_o); // R6

  AST_ERR_NO_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (addr_err_o || !hit_o)) |=> !rvalid_o); // R10

  AST_AERR_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> hit_o); // R10

  AST_CTRL_OFF_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[1:0] != 2'b11) |=> !hit_o); // R11

  AST_CTRL_ON_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[1:0] == 2'b11) |=> (!(req_i && win) || hit_o)); // R11

  always_comb begin
    if (!rst_ni) AST_RESET_IDLE: assert (!rvalid_o); // R12
  end
endmodule

bind car_ram_window car_ram_window_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .hit_o        (hit_o),
  .decode_err_o (decode_err_o),
  .addr_err_o   (addr_err_o),
  .page_o       (page_o),
  .offset_o     (offset_o),
  .rvalid_o     (rvalid_o)
);

// File: tb/car_ram_window_bench.sv
`timescale 1ns/1ps
module car_ram_window_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [2:0]  ctrl_wdata_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        hit_o, decode_err_o, addr_err_o, page_o, rvalid_o;
  logic [13:0] offset_o;
  logic [31:0] rdata_o;

  int n_run = 0, n_fail = 0;
  logic [2:0] m_ctrl = '0;
  logic [7:0] m_mem [8192];

  always #2.5 clk_i = ~clk_i;

  car_ram_window u_car_ram_window (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [2:0] v);
    @(negedge clk_i);
    req_i = 1'b0; ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(posedge clk_i);
    m_ctrl = v;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  function automatic logic [31:0] exp_read(input logic [12:0] o, input logic [1:0] sz);
    logic [31:0] w;
    w = {m_mem[o+3], m_mem[o+2], m_mem[o+1], m_mem[o]};
    case (sz)
      2'd0:    return {{24{w[7]}}, w[7:0]};
      2'd1:    return {{16{w[15]}}, w[15:0]};
      default: return w;
    endcase
  endfunction

  // one access: decode checked before the edge, read data after it
  task automatic do_op(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd, input string tag, input bit chk_dec = 1'b1);
    bit in_w, ok_m, e_hit, e_derr, e_aerr, e_page, go;
    logic [13:0] e_off;
    logic [12:0] mo;
    in_w   = a[31:26] == 6'h1F;
    ok_m   = m_ctrl[1] && m_ctrl[0];
    e_hit  = in_w && ok_m;
    e_derr = in_w && !ok_m;
    e_aerr = e_hit && ((sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 0) || sz == 2'd3);
    e_page = m_ctrl[2] ? a[25] : a[13];
    e_off  = {e_page, 1'b1, a[11:0]};
    mo     = {e_page, a[11:0]};
    go     = e_hit && !e_aerr;
    @(negedge clk_i);
    req_i = 1'b1; we_i = wr; size_i = sz; addr_i = a; wdata_i = wd;
    #1;
    if (chk_dec) begin
      chk({hit_o, decode_err_o, addr_err_o} == {e_hit, e_derr, e_aerr}, {tag, " R1 R2 R10 flags"},
          {hit_o, decode_err_o, addr_err_o}, {e_hit, e_derr, e_aerr});
      if (e_hit)
        chk(page_o == e_page && offset_o == e_off, {tag, (m_ctrl[2] ? " R4" : " R3"), " R5 page/offset"},
            {page_o, offset_o}, {e_page, e_off});
    end
    @(posedge clk_i);
    #1;
    chk(rvalid_o == (go && !wr), {tag, " R6 R10 rvalid"}, rvalid_o, go && !wr);
    if (go && !wr)
      chk(rdata_o == exp_read(mo, sz), {tag, (sz == 0 ? " R6" : sz == 1 ? " R7" : " R8"), " rdata"},
          rdata_o, exp_read(mo, sz));
    if (go && wr) begin
      m_mem[mo] = wd[7:0];
      if (sz != 0) m_mem[mo+1] = wd[15:8];
      if (sz == 2) begin m_mem[mo+2] = wd[23:16]; m_mem[mo+3] = wd[31:24]; end
    end
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #12 rst_ni = 1'b1;
    // R12: reset state
    #1;
    chk(rvalid_o == 1'b0, "R12 rvalid after reset", rvalid_o, 0);
    do_op(1'b0, 2'd2, 32'h7C00_0000, 0, "R12 reset ctrl unmapped");
    chk(decode_err_o == 1'b1, "R12 decode_err after reset", decode_err_o, 1);

    // fill both pages through the port
    set_ctrl(3'b011);
    for (int i = 0; i < 2048; i++)
      do_op(1'b1, 2'd2, 32'h7C00_1000 | ((i / 1024) << 13) | ((i % 1024) << 2),
            {$urandom} ^ i, "fill", 1'b0);

    // directed: sign extension and partial writes
    do_op(1'b1, 2'd2, 32'h7C00_1010, 32'h1234_5678, "R8 setup");
    do_op(1'b1, 2'd0, 32'h7C00_1011, 32'h0000_0080, "R9 byte write");
    do_op(1'b0, 2'd2, 32'h7C00_1010, 0, "R9 merged long");
    do_op(1'b0, 2'd0, 32'h7C00_1011, 0, "R6 negative byte");
    do_op(1'b1, 2'd1, 32'h7C00_1012, 32'hABCD_8001, "R9 word write");
    do_op(1'b0, 2'd1, 32'h7C00_1012, 0, "R7 negative word");
    do_op(1'b1, 2'd1, 32'h7C00_1012, 32'h0000_7FFF, "R9 word write pos");
    do_op(1'b0, 2'd1, 32'h7C00_1012, 0, "R7 positive word");
    do_op(1'b1, 2'd2, 32'h7C00_1012, 32'hDEAD_BEEF, "R10 misaligned long write");
    do_op(1'b0, 2'd2, 32'h7C00_1010, 0, "R10 no write on error");
    do_op(1'b0, 2'd3, 32'h7C00_1010, 0, "R10 reserved size");
    do_op(1'b0, 2'd2, 32'h8000_1000, 0, "R1 above window");
    do_op(1'b0, 2'd2, 32'h7BFF_F000, 0, "R1 below window");
    do_op(1'b0, 2'd2, 32'h7C00_3FFC, 0, "R3 bit13 page1");
    set_ctrl(3'b111);
    do_op(1'b0, 2'd2, 32'h7E00_0FFC, 0, "R4 upper half page1");
    do_op(1'b0, 2'd2, 32'h7DFF_EFFC, 0, "R4 lower half page0");

    // R11: access in the same cycle as a control write uses the old value
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = 3'b001;
    req_i = 1'b1; we_i = 1'b0; size_i = 2'd2; addr_i = 32'h7C00_1000;
    #1;
    chk(hit_o == 1'b1, "R11 same-cycle old ctrl", hit_o, 1);
    @(posedge clk_i);
    m_ctrl = 3'b001;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
    #1;
    chk(hit_o == 1'b0 && decode_err_o == 1'b1, "R11 next-cycle new ctrl R2",
        {hit_o, decode_err_o}, 2'b01);
    do_op(1'b0, 2'd2, 32'h7C00_1000, 0, "R2 ram_en clear");
    set_ctrl(3'b010);
    do_op(1'b0, 2'd2, 32'h7C00_1000, 0, "R2 cache_en clear");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      if ($urandom_range(15) == 0) begin
        logic [2:0] c;
        c = 3'($urandom);
        if ($urandom_range(3) != 0) c[1:0] = 2'b11;
        set_ctrl(c);
      end
      if ($urandom_range(7) == 0) a = $urandom;
      else a = {6'h1F, 26'($urandom)};
      do_op(1'($urandom), 2'($urandom), a, $urandom, "rand");
    end

    @(negedge clk_i);
    req_i = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule